// File: doc/BRIEF.md
# Credit-Gated Connection Message Sender

This block is the transmit-side control for a single logical connection between a host-side client and a far-side firmware client. The host opens the connection by raising a connect request that carries a pair of client identifiers. The connection becomes usable only after the far side answers with a positive connect response. From then on, the pair of identifiers names the connection.

Message transmission is gated by flow-control credit. The far side hands out one credit at a time. Each accepted message spends that credit, and the next message has to wait for a fresh credit. Credits never stack: a credit that arrives while one is still held is flagged as a protocol error.

For every accepted message the block also picks a transport. Short messages go through the register mailbox. A message larger than three 128-byte mailbox fragments is steered to the shared-memory DMA path, but only once DMA has been negotiated on this connection. The block does not move the data itself. It only decides whether a message may go and which path it takes.

Top module: `msg_credit_sender`

## Requirements
- R1: After reset the link is closed. It opens only when a connect request has moved it to the waiting state and a later response arrives with `rsp_ok` high. A response with `rsp_ok` low returns it to closed. A connect request while waiting or open is ignored.
- R2: The host and firmware client IDs sampled with the accepted connect request appear on `host_id`/`fw_id` while the link is open. Both read zero while the link is not open.
- R3: `msg_accept` is high in the same cycle as `msg_valid` only when the link is open, a credit is held, and no disconnect or far reset is present in that cycle.
- R4: An accepted message spends the credit, so `credit_held` is low from the next cycle. The exception is a credit strobe in the same cycle as the accept: that strobe replaces the spent credit and `credit_held` stays high.
- R5: A `disconnect` closes the link in the next cycle. It also clears the held credit and the DMA negotiation.
- R6: A `far_reset` has the same effect as a disconnect.
- R7: An accepted message with `msg_len` greater than 384 bytes (3 fragments of 128 bytes) sets `path_dma` high when DMA is ready. A length of exactly 384 bytes, or any length while DMA is not ready, uses the mailbox (`path_dma` low).
- R8: `dma_ready` becomes high one cycle after `dma_ack` is seen, provided `dma_notify` was seen earlier on the open link. An acknowledge without a prior notify is ignored.
- R9: A credit strobe that arrives while a credit is held and is not spent in that cycle makes `proto_err` high for exactly the next cycle. The held credit stays a single credit.
- R10: A credit strobe while the link is not open is ignored: `credit_held` stays low and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn_req | input | 1 | Connect request strobe |
| req_host_id | input | ID_W | Host client ID sent with the request |
| req_fw_id | input | ID_W | Firmware client ID sent with the request |
| rsp_valid | input | 1 | Connect response strobe |
| rsp_ok | input | 1 | Connect response outcome, 1 = success |
| disconnect | input | 1 | Disconnect request from either side |
| far_reset | input | 1 | Major reset of the far side |
| credit_in | input | 1 | Flow-control credit received |
| dma_notify | input | 1 | DMA allocation notify sent by host |
| dma_ack | input | 1 | DMA allocation acknowledge received |
| msg_valid | input | 1 | Message ready to send |
| msg_len | input | LEN_W | Message length in bytes |
| msg_accept | output | 1 | Message sent this cycle |
| path_dma | output | 1 | 1 = DMA path, 0 = mailbox, valid with accept |
| link_up | output | 1 | Connection open |
| host_id | output | ID_W | Connected host client ID |
| fw_id | output | ID_W | Connected firmware client ID |
| credit_held | output | 1 | A credit is held |
| dma_ready | output | 1 | DMA negotiated |
| proto_err | output | 1 | Surplus credit pulse |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a credit arrival and a message send: a strobe that refills the spent credit must neither raise an error nor leave the link without credit. The second pair is a send and a link drop: the drop must veto the send. Directed cycles put `credit_in` together with `msg_valid` while a credit is held, and `disconnect` together with a sendable message. A long random phase then raises these collisions often. The reference model decides each cycle from the pre-edge state, and every output is compared against it in every cycle.

// File: rtl/msg_credit_pkg.sv
package msg_credit_pkg;
   typedef enum logic [1:0] {
      LINK_DOWN = 2'd0,
      LINK_WAIT = 2'd1,
      LINK_UP   = 2'd2
   } link_state_e;

   typedef enum logic [1:0] {
      DMA_OFF   = 2'd0,
      DMA_ASKED = 2'd1,
      DMA_ON    = 2'd2
   } dma_state_e;
endpackage

// File: rtl/mcs_link_ctrl.sv
module mcs_link_ctrl
   import msg_credit_pkg::*;
#(
   parameter int ID_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            conn_req,
   input  logic [ID_W-1:0] req_host_id,
   input  logic [ID_W-1:0] req_fw_id,
   input  logic            rsp_valid,
   input  logic            rsp_ok,
   input  logic            drop,
   output logic            link_up,
   output logic [ID_W-1:0] host_id,
   output logic [ID_W-1:0] fw_id
);
   link_state_e state_q, state_d;
   logic [ID_W-1:0] hid_q, fid_q;
   logic            take_ids;

   always_comb begin
      state_d  = state_q;
      take_ids = 1'b0;
      if (drop) begin
         state_d = LINK_DOWN;
      end else begin
         unique case (state_q)
            LINK_DOWN: if (conn_req) begin
               state_d  = LINK_WAIT;
               take_ids = 1'b1;
            end
            LINK_WAIT: if (rsp_valid) state_d = rsp_ok ? LINK_UP : LINK_DOWN;
            LINK_UP:   state_d = LINK_UP;
            default:   state_d = LINK_DOWN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LINK_DOWN;
         hid_q   <= '0;
         fid_q   <= '0;
      end else begin
         state_q <= state_d;
         if (take_ids) begin
            hid_q <= req_host_id;
            fid_q <= req_fw_id;
         end
      end
   end

   assign link_up = (state_q == LINK_UP);
   assign host_id = link_up ? hid_q : '0;
   assign fw_id   = link_up ? fid_q : '0;

   // R1: the link only opens on a positive response
   a_r1_open_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_up) |-> $past(rsp_valid && rsp_ok));

   // R2: identifiers stay frozen while open
   a_r2_ids_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && $past(link_up)) |-> ($stable(host_id) && $stable(fw_id)));
endmodule

// File: rtl/mcs_credit_gate.sv
module mcs_credit_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic link_up,
   input  logic drop,
   input  logic credit_in,
   input  logic msg_valid,
   output logic msg_accept,
   output logic credit_held,
   output logic proto_err
);
   logic held_q, held_d, err_q, err_d, live;

   assign live       = link_up && !drop;
   assign msg_accept = msg_valid && live && held_q;

   always_comb begin
      held_d = held_q;
      if (!live)          held_d = 1'b0;
      else if (credit_in) held_d = 1'b1;
      else if (msg_accept) held_d = 1'b0;
      err_d = live && credit_in && held_q && !msg_accept;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         held_q <= held_d;
         err_q  <= err_d;
      end
   end

   assign credit_held = held_q;
   assign proto_err   = err_q;

   // R4: spending without refill leaves no credit
   a_r4_credit_spent: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_accept && !credit_in) |=> !credit_held);

   // R9: an error pulse follows a surplus credit only
   a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> $past(credit_in && credit_held && !msg_accept));

   // R10: a closed link never holds a credit
   a_r10_no_credit_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |-> !credit_held);
endmodule

// File: rtl/mcs_dma_negot.sv
module mcs_dma_negot
   import msg_credit_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic link_up,
   input  logic drop,
   input  logic dma_notify,
   input  logic dma_ack,
   output logic dma_ready
);
   dma_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!link_up || drop) begin
         st_d = DMA_OFF;
      end else begin
         unique case (st_q)
            DMA_OFF:   if (dma_notify) st_d = DMA_ASKED;
            DMA_ASKED: if (dma_ack)    st_d = DMA_ON;
            DMA_ON:    st_d = DMA_ON;
            default:   st_d = DMA_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= DMA_OFF;
      else        st_q <= st_d;
   end

   assign dma_ready = (st_q == DMA_ON);

   // R8: DMA needs an open link and an acknowledge
   a_r8_ready_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ready |-> link_up);
   a_r8_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_ready) |-> $past(dma_ack));
endmodule

// File: rtl/mcs_path_sel.sv
module mcs_path_sel #(
   parameter int LEN_W         = 16,
   parameter int FRAG_BYTES    = 128,
   parameter int DMA_MIN_FRAGS = 3,
   parameter bit DMA_ENABLE    = 1'b1
) (
   input  logic             msg_accept,
   input  logic [LEN_W-1:0] msg_len,
   input  logic             dma_ready,
   output logic             path_dma
);
   localparam int               THRESH_I = FRAG_BYTES * DMA_MIN_FRAGS;
   localparam logic [LEN_W-1:0] THRESH   = LEN_W'(THRESH_I);

   generate
      if (DMA_ENABLE) begin : g_dma
         assign path_dma = msg_accept && dma_ready && (msg_len > THRESH);
      end else begin : g_mbox_only
         logic unused_in;
         assign unused_in = msg_accept ^ dma_ready ^ (^msg_len);
         assign path_dma  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/msg_credit_sender.sv
module msg_credit_sender #(
   parameter int ID_W          = 8,
   parameter int LEN_W         = 16,
   parameter int FRAG_BYTES    = 128,
   parameter int DMA_MIN_FRAGS = 3,
   parameter bit DMA_ENABLE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conn_req,
   input  logic [ID_W-1:0]  req_host_id,
   input  logic [ID_W-1:0]  req_fw_id,
   input  logic             rsp_valid,
   input  logic             rsp_ok,
   input  logic             disconnect,
   input  logic             far_reset,
   input  logic             credit_in,
   input  logic             dma_notify,
   input  logic             dma_ack,
   input  logic             msg_valid,
   input  logic [LEN_W-1:0] msg_len,
   output logic             msg_accept,
   output logic             path_dma,
   output logic             link_up,
   output logic [ID_W-1:0]  host_id,
   output logic [ID_W-1:0]  fw_id,
   output logic             credit_held,
   output logic             dma_ready,
   output logic             proto_err
);
   generate
      if (ID_W < 1 || ID_W > 32) begin : g_bad_id
         $error("ID_W out of range");
      end
      if (FRAG_BYTES < 1 || DMA_MIN_FRAGS < 1) begin : g_bad_frag
         $error("fragment settings must be positive");
      end
      if (FRAG_BYTES * DMA_MIN_FRAGS >= (64'd1 << LEN_W)) begin : g_bad_len
         $error("DMA threshold does not fit in LEN_W");
      end
   endgenerate

   logic drop;
   assign drop = disconnect || far_reset;

   mcs_link_ctrl #(.ID_W(ID_W)) i_link (
      .clk(clk), .rst_n(rst_n), .conn_req(conn_req),
      .req_host_id(req_host_id), .req_fw_id(req_fw_id),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .drop(drop),
      .link_up(link_up), .host_id(host_id), .fw_id(fw_id)
   );

   mcs_credit_gate i_credit (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .drop(drop),
      .credit_in(credit_in), .msg_valid(msg_valid),
      .msg_accept(msg_accept), .credit_held(credit_held), .proto_err(proto_err)
   );

   mcs_dma_negot i_dma (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .drop(drop),
      .dma_notify(dma_notify), .dma_ack(dma_ack), .dma_ready(dma_ready)
   );

   mcs_path_sel #(
      .LEN_W(LEN_W), .FRAG_BYTES(FRAG_BYTES),
      .DMA_MIN_FRAGS(DMA_MIN_FRAGS), .DMA_ENABLE(DMA_ENABLE)
   ) i_path (
      .msg_accept(msg_accept), .msg_len(msg_len),
      .dma_ready(dma_ready), .path_dma(path_dma)
   );

   // R3: nothing is sent on a closed link
   a_r3_send_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
      msg_accept |-> link_up);

   // R5 / R6: a drop closes the link next cycle
   a_r5_drop_closes: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (!link_up && !credit_held && !dma_ready));

   // R7: DMA steering only for accepted messages with DMA ready
   a_r7_dma_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      path_dma |-> (msg_accept && dma_ready));
endmodule

// File: tb/test_msg_credit_sender.sv
`timescale 1ns/1ps
module test_msg_credit_sender;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conn_req = 0, rsp_valid = 0, rsp_ok = 0, disconnect = 0, far_reset = 0;
   logic        credit_in = 0, dma_notify = 0, dma_ack = 0, msg_valid = 0;
   logic [7:0]  req_host_id = 0, req_fw_id = 0;
   logic [15:0] msg_len = 0;
   logic        msg_accept, path_dma, link_up, credit_held, dma_ready, proto_err;
   logic [7:0]  host_id, fw_id;

   int checks = 0, errors = 0;
   bit done = 0;

   // reference model state
   int m_link = 0, m_hid = 0, m_fid = 0, m_dma = 0;
   bit m_credit = 0, m_err = 0;

   always #5 clk = ~clk;

   msg_credit_sender i_msg_credit_sender (
      .clk(clk), .rst_n(rst_n), .conn_req(conn_req),
      .req_host_id(req_host_id), .req_fw_id(req_fw_id),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .disconnect(disconnect),
      .far_reset(far_reset), .credit_in(credit_in), .dma_notify(dma_notify),
      .dma_ack(dma_ack), .msg_valid(msg_valid), .msg_len(msg_len),
      .msg_accept(msg_accept), .path_dma(path_dma), .link_up(link_up),
      .host_id(host_id), .fw_id(fw_id), .credit_held(credit_held),
      .dma_ready(dma_ready), .proto_err(proto_err)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_link = 0; m_hid = 0; m_fid = 0; m_dma = 0; m_credit = 0; m_err = 0;
      end else begin
         bit drop, up, acc;
         drop = disconnect || far_reset;
         up   = (m_link == 2);
         acc  = msg_valid && up && m_credit && !drop;
         m_err = up && !drop && credit_in && m_credit && !acc;
         if (!up || drop)     m_credit = 0;
         else if (credit_in)  m_credit = 1;
         else if (acc)        m_credit = 0;
         if (!up || drop)                  m_dma = 0;
         else if (m_dma == 0 && dma_notify) m_dma = 1;
         else if (m_dma == 1 && dma_ack)    m_dma = 2;
         if (drop) m_link = 0;
         else if (m_link == 0 && conn_req) begin
            m_link = 1; m_hid = req_host_id; m_fid = req_fw_id;
         end else if (m_link == 1 && rsp_valid) m_link = rsp_ok ? 2 : 0;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit up, acc;
      up  = (m_link == 2);
      acc = msg_valid && up && m_credit && !(disconnect || far_reset);
      chk("R1 link_up", link_up, up);
      chk("R2 host_id", host_id, up ? m_hid : 0);
      chk("R2 fw_id", fw_id, up ? m_fid : 0);
      chk("R3 msg_accept", msg_accept, acc);
      chk("R7 path_dma", path_dma, acc && m_dma == 2 && msg_len > 384);
      chk("R4 credit_held", credit_held, m_credit);
      chk("R9 proto_err", proto_err, m_err);
      chk("R8 dma_ready", dma_ready, m_dma == 2);
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
   endtask

   task automatic clear();
      conn_req = 0; rsp_valid = 0; rsp_ok = 0; disconnect = 0; far_reset = 0;
      credit_in = 0; dma_notify = 0; dma_ack = 0; msg_valid = 0;
   endtask

   task automatic open_link(logic [7:0] h, logic [7:0] f);
      clear(); conn_req = 1; req_host_id = h; req_fw_id = f; tick();
      clear(); rsp_valid = 1; rsp_ok = 1; tick();
      clear();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #1;
      compare_all();                       // reset state (R1, R4, R8)
      repeat (3) @(negedge clk);
      rst_n = 1;
      tick();

      // R10: credit on a closed link is ignored
      credit_in = 1; tick(); clear(); tick();

      // R1: negative response keeps the link closed
      conn_req = 1; req_host_id = 8'h11; req_fw_id = 8'h22; tick();
      clear(); rsp_valid = 1; rsp_ok = 0; tick(); clear(); tick();

      // R1/R2: open with IDs, a second request is ignored
      open_link(8'h3A, 8'h5C); tick();
      conn_req = 1; req_host_id = 8'hFF; tick(); clear(); tick();

      // R3/R4: send without credit, then with credit
      msg_valid = 1; msg_len = 16'd40; tick();
      clear(); credit_in = 1; tick(); clear();
      msg_valid = 1; tick(); tick(); clear();

      // R9: surplus credit
      credit_in = 1; tick(); tick(); clear(); tick(); tick();

      // R4: credit and send in the same cycle, no error
      msg_valid = 1; credit_in = 1; tick(); clear(); tick(); tick();

      // R8: ack without notify ignored, then proper negotiation
      dma_ack = 1; tick(); clear(); tick();
      dma_notify = 1; tick(); clear(); dma_ack = 1; tick(); clear(); tick();

      // R7: 384 stays on mailbox, 385 goes DMA
      msg_valid = 1; msg_len = 16'd384; tick(); clear();
      credit_in = 1; tick(); clear();
      msg_valid = 1; msg_len = 16'd385; tick(); clear(); tick();

      // R5: disconnect vetoes a sendable message
      credit_in = 1; tick(); clear();
      msg_valid = 1; msg_len = 16'd900; disconnect = 1; tick(); clear(); tick();

      // R6: far reset drops an open link with DMA ready
      open_link(8'h01, 8'h02);
      dma_notify = 1; tick(); clear(); dma_ack = 1; tick(); clear();
      credit_in = 1; tick(); clear();
      far_reset = 1; tick(); clear(); tick();

      // random collisions of all functions
      for (int i = 0; i < 6000; i++) begin
         int r;
         conn_req    = ($urandom_range(0, 9) == 0);
         req_host_id = 8'($urandom);
         req_fw_id   = 8'($urandom);
         rsp_valid   = ($urandom_range(0, 5) == 0);
         rsp_ok      = ($urandom_range(0, 9) < 8);
         disconnect  = ($urandom_range(0, 99) < 2);
         far_reset   = ($urandom_range(0, 199) == 0);
         credit_in   = ($urandom_range(0, 3) == 0);
         dma_notify  = ($urandom_range(0, 19) == 0);
         dma_ack     = ($urandom_range(0, 9) == 0);
         msg_valid   = ($urandom_range(0, 9) < 4);
         r = $urandom_range(0, 3);
         msg_len = (r == 0) ? 16'd100 : (r == 1) ? 16'd384 : (r == 2) ? 16'd385 : 16'd2000;
         tick();
      end
      clear(); tick();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule